// File: doc/BRIEF.md
# Key-Protected SoC Configuration Register Bank

This block is a bank of chip-level control and status registers on a plain 32-bit register bus. The bus carries a byte offset, a write strobe, write data and combinational read data. The bank drives per-device enable lines, an Ethernet RMII reset line and a privilege word out to the rest of the chip. It reads device status fields, a silicon revision value and a 48-bit fused MAC address in from the chip.

Writes pass through two layers of protection. A two-step kick sequence must open the whole bank first. The device-control word then needs its own lock key as well. Some fields cannot be cleared once set, and the privilege word accepts only one write. Reads are never blocked. Writes that are not accepted are dropped without any response on the bus.

Top module: `cfgbank_top`

## Requirements
- R1: After reset the bank is locked and offset 0x3C reads 0. Offset 0x41C reads 0xAAAAAAAA. Offsets 0x40008, 0x4002C, 0x40020 and 0x40004 read 0. All dev_en bits are 0, rmii_rst is 0 and priv_out is 0xAAAAAAAA.
- R2: The bank opens only after a write of 0x83E70B13 to offset 0x38, followed by a write of 0x95A4F1E0 to offset 0x3C with no other bus write in between. While the bank is open, bit 0 of offset 0x3C reads 1. Idle cycles between the two writes do not matter.
- R3: Any of the following leaves the bank locked and restarts the sequence: a wrong value to either kick offset, a second-key write that does not directly follow a correct first-key write, or any other write between the two keys. Writing the first key again also locks the bank until the second key follows. While the bank is locked, writes to offsets other than 0x38 and 0x3C are dropped.
- R4: Offset 0x40004 is the control lock. While the bank is open, writing 0x0F0A0B00 there sets its bit 0 and any other value clears it. Writes to offset 0x40008 take effect only while that bit is 1.
- R5: Offset 0x40008 holds 2-bit fields. Device d, for d = 0 to 11, owns bits 2d+1:2d, and dev_en[d] is 1 exactly when its field equals 1. Device 12 owns bits 31:30, and dev_en[12] is 1 exactly when that field equals 3.
- R6: Bits 1:0 of offset 0x4002C belong to devices 13 and 14 and drive dev_en[13] and dev_en[14]. A bit can be set by an accepted write but never cleared, because each write ORs into the stored value. The upper bits read 0.
- R7: Status is read-only and comes in 3-bit fields taken from dev_stat_in, where device d owns dev_stat_in[3d+2:3d]. Offset 0x40014 returns devices 0 to 9 packed upward from bit 0. Offset 0x40018 returns devices 10 and 11 packed upward from bit 0. All other bits read 0.
- R8: Bit 18 of offset 0x40020 is the RMII reset. It is written by accepted writes, drives rmii_rst, and is the only bit of that register that reads back non-zero.
- R9: Offset 0x8 reads rev_in in bits 31:28 and 0 elsewhere. Writes to it have no effect.
- R10: Offset 0x700 reads MAC bytes 1 to 4, most significant first, which is mac_fuse_in[47:16]. Offset 0x704 reads bytes 5 and 6 in bits 31:16 and 0 in bits 15:0.
- R11: Offset 0x41C takes only its first accepted write after reset. Later writes are ignored. priv_out always equals the stored value.
- R12: Unmapped offsets and offset 0x38 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 20 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| dev_stat_in | input | 36 | Twelve 3-bit device status fields |
| rev_in | input | 4 | Silicon revision value |
| mac_fuse_in | input | 48 | Fused MAC address, byte 1 in the top byte |
| dev_en | output | 15 | Decoded enable per device id 0 to 14 |
| rmii_rst | output | 1 | RMII reset control |
| priv_out | output | 32 | Privilege word |

## Verification
A wrong kick state appears at the ports one cycle after the write that caused it. Bit 0 of offset 0x3C reads the wrong value, and the next control write is either taken or dropped when it should not be, which changes dev_en, rmii_rst or priv_out on the following edge. A lost lock key, a clear that gets through on the set-only bits, or a second privilege write that gets through all change a registered output one edge after the offending write. The bench compares those outputs with its model on every cycle, so such a fault shows within a single clock. Read-path faults in field packing or byte placement appear immediately on bus_rdata for the offset concerned.

// File: rtl/cfgbank_pkg.sv
// Package: register offsets, unlock keys and kick-state encoding shared by
// the configuration bank modules. Offsets are byte offsets on the bus.
package cfgbank_pkg;
    localparam int unsigned OFF_REV    = 32'h0000_0008;
    localparam int unsigned OFF_KICK0  = 32'h0000_0038;
    localparam int unsigned OFF_KICK1  = 32'h0000_003C;
    localparam int unsigned OFF_MAC_HI = 32'h0000_0700;
    localparam int unsigned OFF_MAC_LO = 32'h0000_0704;
    localparam int unsigned OFF_PRIV   = 32'h0000_041C;
    localparam int unsigned OFF_LOCK   = 32'h0004_0004;
    localparam int unsigned OFF_CTL    = 32'h0004_0008;
    localparam int unsigned OFF_STAT_A = 32'h0004_0014;
    localparam int unsigned OFF_STAT_B = 32'h0004_0018;
    localparam int unsigned OFF_RMII   = 32'h0004_0020;
    localparam int unsigned OFF_PERM   = 32'h0004_002C;

    localparam logic [31:0] KICK_KEY0    = 32'h83E7_0B13;
    localparam logic [31:0] KICK_KEY1    = 32'h95A4_F1E0;
    localparam logic [31:0] CTL_LOCK_KEY = 32'h0F0A_0B00;
    localparam logic [31:0] PRIV_DEFAULT = 32'hAAAA_AAAA;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_ARMED  = 2'd1,
        KS_OPEN   = 2'd2
    } kick_state_e;
endpackage

// File: rtl/cfgbank_kick.sv
// Kick sequencer: tracks the two-key unlock. The first key to the first kick
// offset arms it, and the second key to the second kick offset then opens the
// bank. Any wrong value, out-of-order key, or other write while armed goes
// back to locked. Assumes at most one bus write per cycle.
module cfgbank_kick
    import cfgbank_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic              bank_open
);
    kick_state_e st_q;
    logic        hit_k0;
    logic        hit_k1;

    // Purpose: decode the two kick offsets.
    always_comb begin
        hit_k0 = (addr == ADDR_W'(OFF_KICK0));
        hit_k1 = (addr == ADDR_W'(OFF_KICK1));
    end

    // Purpose: advance the unlock state on each bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= KS_LOCKED;
        end else if (wr_en) begin
            if (hit_k0)
                st_q <= (wdata == KICK_KEY0) ? KS_ARMED : KS_LOCKED;
            else if (hit_k1)
                st_q <= (st_q == KS_ARMED && wdata == KICK_KEY1) ? KS_OPEN : KS_LOCKED;
            else if (st_q == KS_ARMED)
                st_q <= KS_LOCKED;
        end
    end

    assign bank_open = (st_q == KS_OPEN);

    // R2: the bank opens only right after an armed state saw the second key write.
    assert_open_after_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bank_open) |-> ($past(st_q) == KS_ARMED && $past(wr_en) && $past(hit_k1)));

    // R3: a locked bank can never jump straight to open.
    assert_no_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == KS_LOCKED) |=> (st_q != KS_OPEN));
endmodule

// File: rtl/cfgbank_devctl.sv
// Device control: holds the control lock bit, the keyed 2-bit device-control
// word, and the set-only single-bit fields. It decodes per-device enables.
// Assumes bank_open comes from the kick sequencer and that writes are
// single-cycle strobes.
module cfgbank_devctl
    import cfgbank_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int N_MAIN  = 12,
    parameter int MAIN_W  = 2,
    parameter int MAIN_EN = 1,
    parameter int TOP_LSB = 30,
    parameter int TOP_EN  = 3,
    parameter int N_PERM  = 2,
    localparam int N_DEV  = N_MAIN + 1 + N_PERM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              bank_open,
    output logic [31:0]       ctl_q,
    output logic [N_PERM-1:0] perm_q,
    output logic              lock_ok_q,
    output logic [N_DEV-1:0]  dev_en
);
    logic wr_ok;

    // Purpose: a write is eligible only when the bank is open.
    assign wr_ok = wr_en && bank_open;

    // Purpose: control lock bit, set only by the exact key value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_ok_q <= 1'b0;
        else if (wr_ok && addr == ADDR_W'(OFF_LOCK))
            lock_ok_q <= (wdata == CTL_LOCK_KEY);
    end

    // Purpose: keyed device-control word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (wr_ok && lock_ok_q && addr == ADDR_W'(OFF_CTL))
            ctl_q <= wdata;
    end

    // Purpose: set-only enables for devices that cannot be disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            perm_q <= '0;
        else if (wr_ok && addr == ADDR_W'(OFF_PERM))
            perm_q <= perm_q | wdata[N_PERM-1:0];
    end

    // Purpose: decode one enable per packed 2-bit field.
    for (genvar d = 0; d < N_MAIN; d++) begin : g_main
        assign dev_en[d] = (ctl_q[d*MAIN_W +: MAIN_W] == MAIN_W'(MAIN_EN));
    end

    assign dev_en[N_MAIN]              = (ctl_q[TOP_LSB +: MAIN_W] == MAIN_W'(TOP_EN));
    assign dev_en[N_MAIN+1 +: N_PERM]  = perm_q;

    // R4: without the lock key the control word cannot move.
    assert_ctl_needs_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_ok_q |=> $stable(ctl_q));

    // R6: no set-only bit ever clears.
    assert_perm_setonly_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((perm_q & $past(perm_q)) == $past(perm_q)));

    // R3: a locked bank leaves all device-control state untouched.
    assert_locked_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_open |=> ($stable(ctl_q) && $stable(perm_q) && $stable(lock_ok_q)));
endmodule

// File: rtl/cfgbank_misc.sv
// Miscellaneous writable registers: the RMII reset bit and the write-once
// privilege word with its reset default. Assumes bank_open comes from the
// kick sequencer.
module cfgbank_misc
    import cfgbank_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int RMII_BIT = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              bank_open,
    output logic              rmii_q,
    output logic [31:0]       priv_q
);
    logic priv_done_q;
    logic wr_ok;

    // Purpose: a write is eligible only when the bank is open.
    assign wr_ok = wr_en && bank_open;

    // Purpose: RMII reset control bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rmii_q <= 1'b0;
        else if (wr_ok && addr == ADDR_W'(OFF_RMII))
            rmii_q <= wdata[RMII_BIT];
    end

    // Purpose: privilege word, which keeps only its first accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_q      <= PRIV_DEFAULT;
            priv_done_q <= 1'b0;
        end else if (wr_ok && !priv_done_q && addr == ADDR_W'(OFF_PRIV)) begin
            priv_q      <= wdata;
            priv_done_q <= 1'b1;
        end
    end

    // R11: once written, the privilege word never changes again.
    assert_priv_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
        priv_done_q |=> $stable(priv_q));

    // R3: locked writes do not reach the RMII bit.
    assert_rmii_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_open |=> $stable(rmii_q));
endmodule

// File: rtl/cfgbank_rdmux.sv
// Read multiplexer: forms combinational read data from the stored registers
// and the status, revision and fuse inputs. Unmapped offsets read zero.
module cfgbank_rdmux
    import cfgbank_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int STAT_W   = 3,
    parameter int N_STAT_A = 10,
    parameter int N_STAT_B = 2,
    parameter int N_PERM   = 2,
    parameter int REV_W    = 4,
    parameter int RMII_BIT = 18,
    localparam int SA_W    = STAT_W * N_STAT_A,
    localparam int SB_W    = STAT_W * N_STAT_B
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 bank_open,
    input  logic                 lock_ok,
    input  logic [31:0]          ctl_q,
    input  logic [N_PERM-1:0]    perm_q,
    input  logic                 rmii_q,
    input  logic [31:0]          priv_q,
    input  logic [SA_W+SB_W-1:0] stat_in,
    input  logic [REV_W-1:0]     rev_in,
    input  logic [47:0]          mac_in,
    output logic [31:0]          rdata
);
    // Purpose: select and place the read field for the addressed offset.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFF_REV):    rdata[31 -: REV_W] = rev_in;
            ADDR_W'(OFF_KICK1):  rdata[0] = bank_open;
            ADDR_W'(OFF_MAC_HI): rdata = mac_in[47:16];
            ADDR_W'(OFF_MAC_LO): rdata[31:16] = mac_in[15:0];
            ADDR_W'(OFF_PRIV):   rdata = priv_q;
            ADDR_W'(OFF_LOCK):   rdata[0] = lock_ok;
            ADDR_W'(OFF_CTL):    rdata = ctl_q;
            ADDR_W'(OFF_STAT_A): rdata[SA_W-1:0] = stat_in[SA_W-1:0];
            ADDR_W'(OFF_STAT_B): rdata[SB_W-1:0] = stat_in[SA_W +: SB_W];
            ADDR_W'(OFF_RMII):   rdata[RMII_BIT] = rmii_q;
            ADDR_W'(OFF_PERM):   rdata[N_PERM-1:0] = perm_q;
            default:             rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfgbank_top.sv
// Top of the key-protected configuration bank. Ties the kick sequencer,
// device control, miscellaneous registers and read multiplexer to one
// register bus. Reads are combinational and writes take effect on the clock
// edge at which bus_wr is sampled high.
module cfgbank_top #(
    parameter int ADDR_W   = 20,
    parameter int N_MAIN   = 12,
    parameter int N_PERM   = 2,
    parameter int STAT_W   = 3,
    parameter int N_STAT_A = 10,
    parameter int N_STAT_B = 2,
    parameter int REV_W    = 4,
    parameter int RMII_BIT = 18,
    localparam int N_DEV   = N_MAIN + 1 + N_PERM,
    localparam int STAT_BITS = STAT_W * (N_STAT_A + N_STAT_B)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [STAT_BITS-1:0] dev_stat_in,
    input  logic [REV_W-1:0]     rev_in,
    input  logic [47:0]          mac_fuse_in,
    output logic [N_DEV-1:0]     dev_en,
    output logic                 rmii_rst,
    output logic [31:0]          priv_out
);
    logic              bank_open;
    logic [31:0]       ctl_q;
    logic [N_PERM-1:0] perm_q;
    logic              lock_ok;
    logic              rmii_q;
    logic [31:0]       priv_q;

    cfgbank_kick #(.ADDR_W(ADDR_W)) u_kick (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .bank_open(bank_open)
    );

    cfgbank_devctl #(.ADDR_W(ADDR_W), .N_MAIN(N_MAIN), .N_PERM(N_PERM)) u_devctl (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .bank_open(bank_open), .ctl_q(ctl_q),
        .perm_q(perm_q), .lock_ok_q(lock_ok), .dev_en(dev_en)
    );

    cfgbank_misc #(.ADDR_W(ADDR_W), .RMII_BIT(RMII_BIT)) u_misc (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .bank_open(bank_open), .rmii_q(rmii_q),
        .priv_q(priv_q)
    );

    cfgbank_rdmux #(
        .ADDR_W(ADDR_W), .STAT_W(STAT_W), .N_STAT_A(N_STAT_A),
        .N_STAT_B(N_STAT_B), .N_PERM(N_PERM), .REV_W(REV_W), .RMII_BIT(RMII_BIT)
    ) u_rdmux (
        .addr(bus_addr), .bank_open(bank_open), .lock_ok(lock_ok),
        .ctl_q(ctl_q), .perm_q(perm_q), .rmii_q(rmii_q), .priv_q(priv_q),
        .stat_in(dev_stat_in), .rev_in(rev_in), .mac_in(mac_fuse_in),
        .rdata(bus_rdata)
    );

    assign rmii_rst = rmii_q;
    assign priv_out = priv_q;
endmodule

// File: tb/sim_cfgbank_top.sv
`timescale 1ns/1ps
// Bench: behavioural model of the bank, updated on each write and compared
// with the registered outputs on every cycle and with read data on each read.
module sim_cfgbank_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [35:0] dev_stat_in = 36'h9_8765_4321;
    logic [3:0]  rev_in = 4'h5;
    logic [47:0] mac_fuse_in = 48'h0A1B_2C3D_4E5F;
    logic [14:0] dev_en;
    logic        rmii_rst;
    logic [31:0] priv_out;

    int checks = 0;
    int fails = 0;

    // model state
    int          kst = 0;          // 0 locked, 1 armed, 2 open
    bit          m_lock = 0;
    logic [31:0] m_ctl = '0;
    logic [1:0]  m_perm = '0;
    bit          m_rmii = 0;
    logic [31:0] m_priv = 32'hAAAA_AAAA;
    bit          m_pdone = 0;

    cfgbank_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_stat_in(dev_stat_in),
        .rev_in(rev_in), .mac_fuse_in(mac_fuse_in), .dev_en(dev_en),
        .rmii_rst(rmii_rst), .priv_out(priv_out)
    );

    always #10 clk = ~clk;

    task automatic model_apply(input logic [19:0] a, input logic [31:0] d);
        if (a == 20'h38) kst = (d == 32'h83E7_0B13) ? 1 : 0;
        else if (a == 20'h3C) kst = (kst == 1 && d == 32'h95A4_F1E0) ? 2 : 0;
        else if (kst == 1) kst = 0;
        else if (kst == 2) begin
            case (a)
                20'h40004: m_lock = (d == 32'h0F0A_0B00);
                20'h40008: if (m_lock) m_ctl = d;
                20'h4002C: m_perm = m_perm | d[1:0];
                20'h40020: m_rmii = d[18];
                20'h0041C: if (!m_pdone) begin m_priv = d; m_pdone = 1; end
                default: ;
            endcase
        end
    endtask

    function automatic logic [31:0] model_read(input logic [19:0] a);
        logic [31:0] r = '0;
        case (a)
            20'h00008: r = {rev_in, 28'h0};
            20'h0003C: r = {31'h0, kst == 2};
            20'h00700: r = mac_fuse_in[47:16];
            20'h00704: r = {mac_fuse_in[15:0], 16'h0};
            20'h0041C: r = m_priv;
            20'h40004: r = {31'h0, m_lock};
            20'h40008: r = m_ctl;
            20'h40014: r = {2'b00, dev_stat_in[29:0]};
            20'h40018: r = {26'h0, dev_stat_in[35:30]};
            20'h40020: r = {13'h0, m_rmii, 18'h0};
            20'h4002C: r = {30'h0, m_perm};
            default:   r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [14:0] model_en();
        logic [14:0] e;
        for (int d = 0; d < 12; d++) e[d] = (m_ctl[2*d +: 2] == 2'd1);
        e[12] = (m_ctl[31:30] == 2'd3);
        e[14:13] = m_perm;
        return e;
    endfunction

    // Per-cycle comparison of the registered outputs.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (dev_en !== model_en()) begin
                fails++;
                $display("FAIL R5/R6 dev_en got=%h exp=%h", dev_en, model_en());
            end
            checks++;
            if (rmii_rst !== m_rmii) begin
                fails++;
                $display("FAIL R8 rmii_rst got=%b exp=%b", rmii_rst, m_rmii);
            end
            checks++;
            if (priv_out !== m_priv) begin
                fails++;
                $display("FAIL R11 priv_out got=%h exp=%h", priv_out, m_priv);
            end
        end
    end

    task automatic wr(input logic [19:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        model_apply(a, d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [19:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #2;
        e = model_read(a);
        checks++;
        if (bus_rdata !== e) begin
            fails++;
            $display("FAIL %s addr=%h got=%h exp=%h", tag, a, bus_rdata, e);
        end
    endtask

    task automatic open_bank();
        wr(20'h38, 32'h83E7_0B13);
        wr(20'h3C, 32'h95A4_F1E0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(20'h3C, "R1 kick status");
        rd(20'h41C, "R1 priv default");
        rd(20'h40008, "R1 ctl");
        rd(20'h4002C, "R1 perm");
        rd(20'h40020, "R1 rmii");
        rd(20'h40004, "R1 lock");
        rd(20'h00008, "R9 rev");
        rd(20'h00700, "R10 mac hi");
        rd(20'h00704, "R10 mac lo");
        rd(20'h40014, "R7 stat a");
        rd(20'h40018, "R7 stat b");
        rd(20'h00038, "R12 kick0 read");
        rd(20'h00100, "R12 unmapped");

        // R3 locked writes dropped
        wr(20'h40020, 32'hFFFF_FFFF);
        wr(20'h0041C, 32'h1111_1111);
        rd(20'h40020, "R3 locked rmii");
        rd(20'h0041C, "R3 locked priv");
        // R3 second key alone
        wr(20'h3C, 32'h95A4_F1E0);
        rd(20'h3C, "R3 key2 alone");
        // R3 wrong second value
        wr(20'h38, 32'h83E7_0B13);
        wr(20'h3C, 32'h1234_5678);
        rd(20'h3C, "R3 wrong key2");
        // R3 intervening write
        wr(20'h38, 32'h83E7_0B13);
        wr(20'h40020, 32'h0004_0000);
        wr(20'h3C, 32'h95A4_F1E0);
        rd(20'h3C, "R3 intervening write");
        rd(20'h40020, "R3 intervening dropped");
        // R3 wrong first value
        wr(20'h38, 32'h0000_0001);
        wr(20'h3C, 32'h95A4_F1E0);
        rd(20'h3C, "R3 wrong key1");

        // R2 proper sequence with idle gap
        wr(20'h38, 32'h83E7_0B13);
        repeat (3) @(negedge clk);
        wr(20'h3C, 32'h95A4_F1E0);
        rd(20'h3C, "R2 open");

        // R4 control needs its lock key
        wr(20'h40008, 32'hFFFF_FFFF);
        rd(20'h40008, "R4 ctl without key");
        wr(20'h40004, 32'h0F0A_0B01);
        rd(20'h40004, "R4 wrong lock");
        wr(20'h40004, 32'h0F0A_0B00);
        rd(20'h40004, "R4 lock set");

        // R5 field decode
        wr(20'h40008, 32'hC055_5555);
        rd(20'h40008, "R5 all on");
        wr(20'h40008, 32'h4000_0009);
        rd(20'h40008, "R5 mixed");
        wr(20'h40008, 32'hAAAA_AAA6);
        rd(20'h40008, "R5 pattern");
        wr(20'h40004, 32'h0);
        wr(20'h40008, 32'h0000_0000);
        rd(20'h40008, "R4 relocked ctl");

        // R6 set-only bits
        wr(20'h4002C, 32'h1);
        rd(20'h4002C, "R6 set bit0");
        wr(20'h4002C, 32'hFFFF_FFFE);
        rd(20'h4002C, "R6 set bit1");
        wr(20'h4002C, 32'h0);
        rd(20'h4002C, "R6 clear ignored");

        // R8 rmii bit
        wr(20'h40020, 32'h0004_0000);
        rd(20'h40020, "R8 rmii set");
        wr(20'h40020, 32'hFFFB_FFFF);
        rd(20'h40020, "R8 rmii clear");
        wr(20'h40020, 32'hFFFF_FFFF);
        rd(20'h40020, "R8 rmii only bit");

        // R9 rev read-only
        wr(20'h00008, 32'h0000_0000);
        rd(20'h00008, "R9 rev write ignored");

        // R11 write-once privilege
        wr(20'h0041C, 32'h1234_5678);
        rd(20'h0041C, "R11 first write");
        wr(20'h0041C, 32'h0);
        rd(20'h0041C, "R11 second ignored");

        // R3 relock by bad kick value, then writes dropped
        wr(20'h38, 32'hDEAD_BEEF);
        rd(20'h3C, "R3 relock");
        wr(20'h40020, 32'h0);
        rd(20'h40020, "R3 relock drop");
        // R3 first key while open locks until key2
        open_bank();
        wr(20'h38, 32'h83E7_0B13);
        rd(20'h3C, "R3 rearm locks");
        wr(20'h3C, 32'h95A4_F1E0);
        rd(20'h3C, "R2 reopen");

        // R7 R9 R10 with new inputs
        @(negedge clk);
        dev_stat_in = 36'hF_FFFF_FFFF;
        rev_in = 4'hC;
        mac_fuse_in = 48'hFEDC_BA98_7654;
        rd(20'h40014, "R7 stat a ones");
        rd(20'h40018, "R7 stat b ones");
        rd(20'h00008, "R9 rev new");
        rd(20'h00700, "R10 mac hi new");
        rd(20'h00704, "R10 mac lo new");

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1 got=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule